// File: doc/BRIEF.md
# Serial EEPROM Command Guard

This block is the command-acceptance and write-protection front end of a serial EEPROM slave with a 16K x 8 array. It oversamples SPI mode-0 traffic (active-low select, serial clock, data in) on the system clock and decodes six commands. These are: set write enable (06h), clear write enable (04h), read status (05h), write status (01h), read array (03h) and write array (02h). It holds a status byte made of a write-enable flag, a two-bit protected-region code and a status-lock bit. The active-low write-protect pin works together with the status-lock bit to freeze that status byte.

A modifying command counts only if select is released on a byte boundary after the last bit the command needs. When a write-array command is accepted, the block emits a one-cycle commit strobe. The strobe carries the start address, the end address after wrapping inside a 64-byte page, the byte count and the last data byte. An external array model serves read data through an address output and a data input. The write-in-progress bit is always zero.

Top module: `eeprom_guard`

## Requirements
- R1: Read status (05h) shifts out the status byte MSB first and repeats it on each further byte while selected. The layout is bit 7 status-lock, bits 3:2 protected-region code, bit 1 write-enable, and bits 6:4 and 0 read zero. After reset the status byte is 00h.
- R2: Set write enable (06h) sets bit 1 and clear write enable (04h) clears it. Each takes effect only when select rises after exactly 8 clocks.
- R3: Write status (01h) needs write enable set and exactly 16 clocks. It loads bits 7 and 3:2 from the data byte, ignores the other data bits and clears write enable. Any other clock count leaves the status unchanged.
- R4: Write array (02h) needs at least 32 clocks and a clock count that is a multiple of 8. Otherwise it is discarded with no commit, and write enable keeps its value.
- R5: Write array with write enable clear never commits.
- R6: The protected region follows the code: 00 none, 01 addresses 3000h-3FFFh, 10 addresses 2000h-3FFFh, 11 everything. A write array whose start address lies in the region produces no commit and keeps write enable set.
- R7: An accepted write array raises commitValid for exactly one cycle and clears write enable. It reports the start address (the low 14 bits of the 16-bit address), the last data byte, and the byte count, which saturates at 64. It also reports the address of the last byte, wrapping within the 64-byte page.
- R8: With status-lock = 1 and wpN low, write status is rejected, the status bits do not change and write enable stays set.
- R9: Read array uses the low 14 bits of the 16-bit address. Each data byte comes from rdData at rdAddr and is shifted out MSB first on falling clock edges, and the address increments and wraps from 3FFFh to 0000h.
- R10: An unknown opcode is ignored until select is released: no commit, no status change, and miso stays 0.
- R11: miso is 0 while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the block |
| wpN | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data out of the block |
| rdAddr | output | 14 | Array address for the next read byte |
| rdData | input | 8 | Array byte at rdAddr |
| commitValid | output | 1 | One-cycle strobe for an accepted array write |
| commitAddr | output | 14 | Start address of the committed write |
| commitEndAddr | output | 14 | Page-wrapped address of the last byte written |
| commitData | output | 8 | Last data byte received |
| commitCount | output | 7 | Number of data bytes, saturating at 64 |

## Verification
On every cycle the checker confirms four things. The commit strobe lasts a single cycle and never points into the protected region. Write enable is already clear when the strobe shows. The reserved status bits stay zero, and miso is quiet while deselected. The status bits also must not move while the lock bit is set and the pin is low. Only the bench scenarios can show the framing rules: the exact clock counts, and discarding commands that stop off a byte boundary. The same holds for page wrap and count saturation, the read address wrap, and the serial bit order.

// File: rtl/eg_pkg.sv
package eg_pkg;
  typedef enum logic [2:0] {
    CmdNone, CmdWren, CmdWrdi, CmdRdsr, CmdWrsr, CmdRead, CmdWrite
  } cmd_e;

  typedef struct packed {
    logic frameStart;
    logic bitIn;
    logic addrHiStb;
    logic addrLoStb;
    logic dataStb;
    logic outLoadStatus;
    logic outLoadArray;
    logic outShift;
  } dpCtl_t;

  function automatic cmd_e decodeOp(input logic [7:0] op);
    case (op)
      8'h06:   return CmdWren;
      8'h04:   return CmdWrdi;
      8'h05:   return CmdRdsr;
      8'h01:   return CmdWrsr;
      8'h03:   return CmdRead;
      8'h02:   return CmdWrite;
      default: return CmdNone;
    endcase
  endfunction
endpackage

// File: rtl/eg_ctrl.sv
module eg_ctrl
  import eg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         sclk,
  input  logic         wpN,
  input  logic [7:0]   rxNext,
  input  logic         newSrwd,
  input  logic [1:0]   newBp,
  input  logic [1:0]   guardBits,
  output dpCtl_t       ctl,
  output logic [7:0]   statusByte,
  output logic         commitValid,
  output logic         csIdle
);
  logic csS, csD, sclkS, sclkD, wpS;
  logic sclkRise, sclkFall, csRise, csFall;
  logic [2:0] bitPos;
  logic [3:0] byteCnt;
  cmd_e cmd;
  logic wel, srwd;
  logic [1:0] bp;
  logic byteDone, aligned, hwLock, inRegion, isAddrCmd, boundary;
  logic wrenOk, wrdiOk, wrsrOk, writeOk;

  // pin sampling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csS <= 1'b1; csD <= 1'b1; sclkS <= 1'b0; sclkD <= 1'b0; wpS <= 1'b1;
    end else begin
      csS <= csN; csD <= csS; sclkS <= sclk; sclkD <= sclkS; wpS <= wpN;
    end
  end

  always_comb begin
    sclkRise = sclkS & ~sclkD & ~csS;
    sclkFall = ~sclkS & sclkD & ~csS;
    csFall   = ~csS & csD;
    csRise   = csS & ~csD;
    byteDone = sclkRise && (bitPos == 3'd7);
    aligned  = (bitPos == 3'd0);
    hwLock   = srwd & ~wpS;
    case (bp)
      2'b00:   inRegion = 1'b0;
      2'b01:   inRegion = (guardBits == 2'b11);
      2'b10:   inRegion = guardBits[1];
      default: inRegion = 1'b1;
    endcase
    isAddrCmd = (cmd == CmdRead) || (cmd == CmdWrite);
    boundary  = sclkFall && aligned;
  end

  // frame counters and opcode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPos <= '0; byteCnt <= '0; cmd <= CmdNone;
    end else if (csFall) begin
      bitPos <= '0; byteCnt <= '0; cmd <= CmdNone;
    end else if (sclkRise) begin
      bitPos <= bitPos + 3'd1;
      if (byteDone) begin
        if (byteCnt != 4'hF) byteCnt <= byteCnt + 4'd1;
        if (byteCnt == 4'd0) cmd <= decodeOp(rxNext);
      end
    end
  end

  // strobes to the datapath
  always_comb begin
    ctl.frameStart    = csFall;
    ctl.bitIn         = sclkRise;
    ctl.addrHiStb     = byteDone && isAddrCmd && (byteCnt == 4'd1);
    ctl.addrLoStb     = byteDone && isAddrCmd && (byteCnt == 4'd2);
    ctl.dataStb       = byteDone && (((cmd == CmdWrsr) && (byteCnt == 4'd1)) ||
                                     ((cmd == CmdWrite) && (byteCnt >= 4'd3)));
    ctl.outLoadStatus = boundary && (cmd == CmdRdsr);
    ctl.outLoadArray  = boundary && (cmd == CmdRead) && (byteCnt >= 4'd3);
    ctl.outShift      = sclkFall && !(ctl.outLoadStatus || ctl.outLoadArray);
  end

  // acceptance at select release
  always_comb begin
    wrenOk  = csRise && aligned && (cmd == CmdWren) && (byteCnt == 4'd1);
    wrdiOk  = csRise && aligned && (cmd == CmdWrdi) && (byteCnt == 4'd1);
    wrsrOk  = csRise && aligned && (cmd == CmdWrsr) && (byteCnt == 4'd2) && wel && !hwLock;
    writeOk = csRise && aligned && (cmd == CmdWrite) && (byteCnt >= 4'd4) && wel && !inRegion;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel <= 1'b0; srwd <= 1'b0; bp <= 2'b00; commitValid <= 1'b0;
    end else begin
      if (wrenOk) wel <= 1'b1;
      else if (wrdiOk || wrsrOk || writeOk) wel <= 1'b0;
      if (wrsrOk) begin
        srwd <= newSrwd;
        bp   <= newBp;
      end
      commitValid <= writeOk;
    end
  end

  assign statusByte = {srwd, 3'b000, bp, wel, 1'b0};
  assign csIdle     = csS;
endmodule

// File: rtl/eg_datapath.sv
module eg_datapath
  import eg_pkg::*;
#(
  parameter int AddrW = 14,
  parameter int PageW = 6,
  localparam int CntW = PageW + 1,
  localparam int HiW  = AddrW - 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mosi,
  input  dpCtl_t           ctl,
  input  logic [7:0]       statusByte,
  input  logic [7:0]       rdData,
  output logic [7:0]       rxNext,
  output logic [7:0]       dataByte,
  output logic [AddrW-1:0] wrStart,
  output logic [AddrW-1:0] wrEnd,
  output logic [CntW-1:0]  wrCount,
  output logic [AddrW-1:0] rdAddr,
  output logic             outBit
);
  localparam logic [CntW-1:0] PageBytes = CntW'(1 << PageW);

  logic mosiS;
  logic [7:0] rxShift, txShift;
  logic [HiW-1:0] addrHi;
  logic [AddrW-1:0] rdPtr;

  assign rxNext = {rxShift[6:0], mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mosiS <= 1'b0; rxShift <= '0; addrHi <= '0; wrStart <= '0; rdPtr <= '0;
      dataByte <= '0; wrEnd <= '0; wrCount <= '0; txShift <= '0;
    end else begin
      mosiS <= mosi;
      if (ctl.frameStart) begin
        rxShift <= '0;
        wrCount <= '0;
        txShift <= '0;
      end else begin
        if (ctl.bitIn) rxShift <= rxNext;
        if (ctl.addrHiStb) addrHi <= rxNext[HiW-1:0];
        if (ctl.addrLoStb) begin
          wrStart <= {addrHi, rxNext};
          rdPtr   <= {addrHi, rxNext};
        end
        if (ctl.dataStb) begin
          dataByte <= rxNext;
          if (wrCount == '0) wrEnd <= wrStart;
          else wrEnd <= {wrEnd[AddrW-1:PageW], wrEnd[PageW-1:0] + 1'b1};
          if (wrCount != PageBytes) wrCount <= wrCount + 1'b1;
        end
        if (ctl.outLoadStatus) txShift <= statusByte;
        else if (ctl.outLoadArray) begin
          txShift <= rdData;
          rdPtr   <= rdPtr + 1'b1;
        end else if (ctl.outShift) txShift <= {txShift[6:0], 1'b0};
      end
    end
  end

  assign rdAddr = rdPtr;
  assign outBit = txShift[7];
endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard
  import eg_pkg::*;
#(
  parameter int AddrW = 14,
  parameter int PageW = 6,
  localparam int CntW = PageW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic             mosi,
  input  logic             wpN,
  output logic             miso,
  output logic [AddrW-1:0] rdAddr,
  input  logic [7:0]       rdData,
  output logic             commitValid,
  output logic [AddrW-1:0] commitAddr,
  output logic [AddrW-1:0] commitEndAddr,
  output logic [7:0]       commitData,
  output logic [CntW-1:0]  commitCount
);
  dpCtl_t ctl;
  logic [7:0] statusByte, rxNext, dataByte;
  logic csIdle, outBit;

  eg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .wpN(wpN),
    .rxNext(rxNext), .newSrwd(dataByte[7]), .newBp(dataByte[3:2]),
    .guardBits(commitAddr[AddrW-1 -: 2]), .ctl(ctl), .statusByte(statusByte),
    .commitValid(commitValid), .csIdle(csIdle)
  );

  eg_datapath #(.AddrW(AddrW), .PageW(PageW)) u_dp (
    .clk(clk), .rstN(rstN), .mosi(mosi), .ctl(ctl), .statusByte(statusByte),
    .rdData(rdData), .rxNext(rxNext), .dataByte(dataByte), .wrStart(commitAddr),
    .wrEnd(commitEndAddr), .wrCount(commitCount), .rdAddr(rdAddr), .outBit(outBit)
  );

  assign commitData = dataByte;
  assign miso = outBit & ~csIdle;
endmodule

// File: rtl/eg_guard_chk.sv
module eg_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       wpN,
  input logic       miso,
  input logic       commitValid,
  input logic [1:0] guardBits,
  input logic [7:0] statusByte
);
  logic hit;
  always_comb begin
    case (statusByte[3:2])
      2'b00:   hit = 1'b0;
      2'b01:   hit = guardBits == 2'b11;
      2'b10:   hit = guardBits[1];
      default: hit = 1'b1;
    endcase
  end

  p_commit_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |=> !commitValid);
  p_commit_clears_wel_r7: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> !statusByte[1]);
  p_commit_outside_region_r6: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> !hit);
  p_status_reserved_r1: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[6:4] == 3'b000) && !statusByte[0]);
  p_lock_freeze_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wpN, 2) && $past(statusByte[7])) |->
      ({statusByte[7], statusByte[3:2]} == {$past(statusByte[7]), $past(statusByte[3:2])}));
  p_miso_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN) |-> !miso);
endmodule

bind eeprom_guard eg_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .wpN(wpN), .miso(miso),
  .commitValid(commitValid), .guardBits(commitAddr[AddrW-1 -: 2]),
  .statusByte(statusByte)
);

// File: tb/sim_eeprom_guard.sv
`timescale 1ns/1ps
module sim_eeprom_guard;
  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, mosi = 1'b0, wpN = 1'b1;
  logic miso, commitValid;
  logic [13:0] rdAddr, commitAddr, commitEndAddr;
  logic [7:0] rdData, commitData;
  logic [6:0] commitCount;
  int checks = 0, errors = 0, commitSeen = 0;
  logic [13:0] capAddr, capEnd;
  logic [7:0] capData;
  logic [6:0] capCount;
  logic [7:0] txBuf [0:71];
  logic [7:0] rxBuf [0:71];
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] arrayByte(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]};
  endfunction
  assign rdData = arrayByte(rdAddr);

  eeprom_guard u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .wpN(wpN),
    .miso(miso), .rdAddr(rdAddr), .rdData(rdData), .commitValid(commitValid),
    .commitAddr(commitAddr), .commitEndAddr(commitEndAddr), .commitData(commitData),
    .commitCount(commitCount)
  );

  always @(negedge clk) if (commitValid) begin
    commitSeen++;
    capAddr = commitAddr; capEnd = commitEndAddr; capData = commitData; capCount = commitCount;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic spiBit(input logic b, output logic r);
    mosi = b;
    repeat (3) @(negedge clk);
    r = miso;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic frame(input int nBytes, input int extraBits);
    logic r;
    csN = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nBytes; i++) begin
      for (int b = 7; b >= 0; b--) begin
        spiBit(txBuf[i][b], r);
        rxBuf[i][b] = r;
      end
    end
    for (int e = 0; e < extraBits; e++) spiBit(1'b1, r);
    repeat (2) @(negedge clk);
    csN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic op1(input logic [7:0] op);
    txBuf[0] = op; frame(1, 0);
  endtask

  task automatic wrsr(input logic [7:0] v);
    txBuf[0] = 8'h01; txBuf[1] = v; frame(2, 0);
  endtask

  task automatic readStatus(output logic [7:0] s);
    txBuf[0] = 8'h05; txBuf[1] = 8'h00; frame(2, 0);
    s = rxBuf[1];
  endtask

  task automatic writeArr(input logic [15:0] a, input int n, input logic [7:0] seed, input int extra);
    txBuf[0] = 8'h02; txBuf[1] = a[15:8]; txBuf[2] = a[7:0];
    for (int k = 0; k < n; k++) txBuf[3 + k] = seed + 8'(k);
    commitSeen = 0;
    frame(3 + n, extra);
  endtask

  // {region code, write address, commit expected}
  localparam logic [16:0] VEC [0:7] = '{
    {2'b00, 14'h3FFF, 1'b1}, {2'b01, 14'h2FFF, 1'b1},
    {2'b01, 14'h3000, 1'b0}, {2'b10, 14'h1FFF, 1'b1},
    {2'b10, 14'h2000, 1'b0}, {2'b11, 14'h0000, 1'b0},
    {2'b01, 14'h3FFF, 1'b0}, {2'b10, 14'h0ABC, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state, R11 idle output
    check("R11 miso idle", miso, 0);
    check("R7 no commit after reset", commitValid, 0);
    readStatus(s); check("R1 reset status", s, 8'h00);

    // R2 set / clear write enable
    op1(8'h06); readStatus(s); check("R2 set write enable", s, 8'h02);
    op1(8'h04); readStatus(s); check("R2 clear write enable", s, 8'h00);
    txBuf[0] = 8'h06; txBuf[1] = 8'h00; frame(2, 0);
    readStatus(s); check("R2 set with 16 clocks ignored", s, 8'h00);

    // R1 repeat of status while selected
    op1(8'h06);
    txBuf[0] = 8'h05; txBuf[1] = 8'h00; txBuf[2] = 8'h00; frame(3, 0);
    check("R1 status byte 1", rxBuf[1], 8'h02);
    check("R1 status byte repeat", rxBuf[2], 8'h02);

    // R4 framing
    writeArr(16'h0000, 1, 8'h11, 7);
    check("R4 off-boundary write commits", commitSeen, 0);
    readStatus(s); check("R4 write enable kept", s, 8'h02);
    writeArr(16'h0000, 0, 8'h11, 0);
    check("R4 write without data commits", commitSeen, 0);
    op1(8'h04);

    // R5 no write enable
    writeArr(16'h0100, 2, 8'h22, 0);
    check("R5 write without enable", commitSeen, 0);

    // R6 region table
    for (int i = 0; i < 8; i++) begin
      op1(8'h06); wrsr({4'b0000, VEC[i][16:15], 2'b00});
      op1(8'h06);
      writeArr({2'b00, VEC[i][14:1]}, 1, 8'h5A, 0);
      check($sformatf("R6 vector %0d commit", i), commitSeen, 32'(VEC[i][0]));
      readStatus(s);
      check($sformatf("R6 vector %0d status", i), s, {4'b0000, VEC[i][16:15], ~VEC[i][0], 1'b0});
      op1(8'h04);
    end
    op1(8'h06); wrsr(8'h00);

    // R7 commit contents and page wrap
    op1(8'h06);
    writeArr(16'hC13E, 4, 8'hA0, 0);
    check("R7 commit count pulses", commitSeen, 1);
    check("R7 start address", capAddr, 14'h013E);
    check("R7 end address wraps in page", capEnd, 14'h0101);
    check("R7 byte count", capCount, 7'd4);
    check("R7 last data", capData, 8'hA3);
    readStatus(s); check("R7 write enable cleared", s, 8'h00);
    op1(8'h06);
    writeArr(16'h0040, 66, 8'h10, 0);
    check("R7 saturated count", capCount, 7'd64);
    check("R7 saturated end address", capEnd, 14'h0041);
    check("R7 saturated last data", capData, 8'h51);

    // R3 write status and ignored bits; R8 lock
    op1(8'h06); wrsr(8'hF3);
    readStatus(s); check("R3 write status bits", s, 8'h80);
    wpN = 1'b0; repeat (3) @(negedge clk);
    op1(8'h06); wrsr(8'h8C);
    readStatus(s); check("R8 locked write status", s, 8'h82);
    wpN = 1'b1; repeat (3) @(negedge clk);
    wrsr(8'h0C);
    readStatus(s); check("R8 unlocked by pin", s, 8'h0C);
    op1(8'h06); wrsr(8'h00);
    readStatus(s); check("R3 clear region", s, 8'h00);
    op1(8'h06);
    txBuf[0] = 8'h01; txBuf[1] = 8'h0C; txBuf[2] = 8'h00; frame(3, 0);
    readStatus(s); check("R3 24-clock write status", s, 8'h02);
    op1(8'h04);

    // R9 read with wrap
    txBuf[0] = 8'h03; txBuf[1] = 8'h7F; txBuf[2] = 8'hFE;
    txBuf[3] = 8'h00; txBuf[4] = 8'h00; txBuf[5] = 8'h00;
    frame(6, 0);
    check("R9 read byte 0", rxBuf[3], arrayByte(14'h3FFE));
    check("R9 read byte 1", rxBuf[4], arrayByte(14'h3FFF));
    check("R9 read wraps", rxBuf[5], arrayByte(14'h0000));

    // R10 unknown opcode
    op1(8'h06);
    txBuf[0] = 8'h0F; txBuf[1] = 8'h02; txBuf[2] = 8'h00; txBuf[3] = 8'h00;
    commitSeen = 0; frame(4, 0);
    check("R10 unknown opcode commit", commitSeen, 0);
    check("R10 unknown opcode miso", {rxBuf[1], rxBuf[2], rxBuf[3]}, 24'h0);
    readStatus(s); check("R10 unknown opcode status", s, 8'h02);
    check("R11 miso idle after frames", miso, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule